// File: doc/BRIEF.md
# SIR Receive Frame Unwrapping Filter

This block sits behind a serial infrared byte receiver. It takes decoded bytes one at a time and removes the asynchronous framing around each packet. Bytes that arrive outside a frame, such as preamble fill, are thrown away. A packet starts at the opening flag 0xC0 and ends at the closing flag 0xC1. Repeated opening flags are absorbed, and an escape byte 0x7D is dropped while the byte after it is restored by XOR with 0x20. What remains is the address, control, information and 16-bit check sequence. These bytes leave on a byte stream marked with start-of-packet and end-of-packet.

The output holds one byte back. This lets end-of-packet, together with the error status of the frame, ride on the same beat as the last payload byte. A frame that closes with no payload produces a single zero-length marker beat. A per-packet counter of forwarded bytes is visible at all times. A programmable limit caps the packet length. Two framing faults are reported separately: an opening flag that arrives inside a frame already carrying payload, and an escape byte followed directly by the closing flag. The frame check sequence itself is not checked here.

Top module: `sir_deframer`

## Requirements
- R1: `flag_word` reads 16'hC1C0 at all times: the closing flag 0xC1 in bits [15:8] and the opening flag 0xC0 in bits [7:0].
- R2: While no frame is open, every input byte other than 0xC0 (including 0xFF fill and a stray 0xC1) is discarded, produces no output beat and leaves `byte_count` unchanged.
- R3: A 0xC0 opens a frame. Further 0xC0 bytes that arrive before any byte has been counted in that frame are absorbed without output.
- R4: Inside a frame, the escape byte 0x7D produces no output, and the next non-flag byte is forwarded XORed with 0x20 (0x7D 0x5E gives 0x7E, 0x7D 0x5D gives 0x7D).
- R5: Every other byte between the flags, including the two trailing check bytes, is forwarded in order. A payload byte appears on the output, registered, in the cycle after the next payload byte or the closing flag is accepted. `out_sop` marks the first beat of a packet.
- R6: `out_eop` is set on the same beat as the last payload byte. A frame closed with no payload gives one beat with `out_empty`, `out_sop` and `out_eop` all set and `out_byte` equal to 0.
- R7: A 0xC0 arriving after at least one byte has been counted in the open frame closes that frame with `out_err_noend` set on its end beat and immediately opens a new frame.
- R8: A 0xC1 that directly follows an escape byte closes the frame with `out_err_frame` set on the end beat.
- R9: `byte_count` is cleared when a frame opens, rises by one for each forwarded byte, and holds its value after the frame closes until the next frame opens.
- R10: Once `byte_count` equals `max_len`, further payload bytes of the frame are dropped and `out_err_len` is set on the end beat. A frame of exactly `max_len` bytes carries no length error.
- R11: `out_sop`, `out_eop`, `out_empty` and the error flags are only ever set together with `out_valid`, and the error flags only on an end beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Decoded received byte |
| max_len | input | 12 | Largest accepted packet length in bytes |
| out_valid | output | 1 | Output beat strobe |
| out_byte | output | 8 | Unwrapped payload byte (0 on a zero-length marker) |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_empty | output | 1 | End beat carries no byte |
| out_err_noend | output | 1 | Frame was cut short by a new opening flag |
| out_err_frame | output | 1 | Escape byte directly before the closing flag |
| out_err_len | output | 1 | Frame exceeded `max_len` |
| byte_count | output | 12 | Bytes forwarded in the current or last packet |
| flag_word | output | 16 | Closing flag in [15:8], opening flag in [7:0] |

## Verification
The assertions check the qualities of the output stream that hold on every cycle:
- markers and errors appear only on valid beats, and errors only on end beats;
- a zero-length marker always carries both start and end;
- no beat appears without an input byte in the cycle before;
- the counter only clears, holds or steps by one, and never steps past the limit.

What those beats contain can only be shown by the directed scenarios. The scenarios cover:
- the held-back byte order and its one-beat delay;
- un-escaping;
- discarding of fill and stray flags;
- the separate missing-end and escape-before-end faults;
- the exact length boundary.

// File: rtl/sir_deframer_pkg.sv
package sir_deframer_pkg;

    localparam int          BYTE_W    = 8;
    localparam int          DEF_LEN_W = 12;
    localparam logic [7:0]  OPEN_FLAG  = 8'hC0;
    localparam logic [7:0]  CLOSE_FLAG = 8'hC1;
    localparam logic [7:0]  ESC_CODE   = 8'h7D;
    localparam logic [7:0]  ESC_XOR    = 8'h20;
    localparam logic [15:0] FLAG_PAIR  = {CLOSE_FLAG, OPEN_FLAG};

    typedef enum logic [1:0] {
        SYM_DATA,
        SYM_OPEN,
        SYM_CLOSE,
        SYM_ESC
    } sym_e;

    typedef struct packed {
        logic noend;
        logic frame;
        logic len;
    } ferr_t;

    typedef struct packed {
        logic             valid;
        logic [BYTE_W-1:0] data;
        logic             sop;
        logic             eop;
        logic             empty;
        ferr_t            err;
    } beat_t;

    function automatic sym_e classify(input logic [BYTE_W-1:0] b);
        if (b == OPEN_FLAG)       return SYM_OPEN;
        else if (b == CLOSE_FLAG) return SYM_CLOSE;
        else if (b == ESC_CODE)   return SYM_ESC;
        else                      return SYM_DATA;
    endfunction

endpackage

// File: rtl/sir_deframer_classify.sv
module sir_deframer_classify
    import sir_deframer_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output sym_e              sym
);
    assign sym = classify(byte_in);
endmodule

// File: rtl/sir_deframer_core.sv
module sir_deframer_core
    import sir_deframer_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  sym_e              sym,
    input  logic [LEN_W-1:0]  max_len,
    output logic              pay_v,
    output logic [BYTE_W-1:0] pay_d,
    output logic              close_v,
    output ferr_t             close_err,
    output logic [LEN_W-1:0]  count
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic             in_frame, in_frame_n;
    logic             esc, esc_n;
    logic             len_err, len_err_n;
    logic [LEN_W-1:0] cnt_n;

    always_comb begin
        pay_v      = 1'b0;
        pay_d      = esc ? (in_byte ^ ESC_XOR) : in_byte;
        close_v    = 1'b0;
        close_err  = '0;
        in_frame_n = in_frame;
        esc_n      = esc;
        len_err_n  = len_err;
        cnt_n      = count;
        if (in_valid) begin
            if (!in_frame) begin
                if (sym == SYM_OPEN) begin
                    in_frame_n = 1'b1;
                    esc_n      = 1'b0;
                    len_err_n  = 1'b0;
                    cnt_n      = '0;
                end
            end else if (sym == SYM_OPEN) begin
                esc_n = 1'b0;
                if (count != '0 || len_err) begin
                    close_v         = 1'b1;
                    close_err.noend = 1'b1;
                    close_err.len   = len_err;
                    len_err_n       = 1'b0;
                    cnt_n           = '0;
                end
            end else if (sym == SYM_CLOSE) begin
                close_v         = 1'b1;
                close_err.frame = esc;
                close_err.len   = len_err;
                in_frame_n      = 1'b0;
                esc_n           = 1'b0;
            end else if (sym == SYM_ESC && !esc) begin
                esc_n = 1'b1;
            end else begin
                esc_n = 1'b0;
                if (count < max_len) begin
                    pay_v = 1'b1;
                    cnt_n = count + ONE;
                end else begin
                    len_err_n = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            esc      <= 1'b0;
            len_err  <= 1'b0;
            count    <= '0;
        end else begin
            in_frame <= in_frame_n;
            esc      <= esc_n;
            len_err  <= len_err_n;
            count    <= cnt_n;
        end
    end
endmodule

// File: rtl/sir_deframer_outstage.sv
module sir_deframer_outstage
    import sir_deframer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pay_v,
    input  logic [BYTE_W-1:0] pay_d,
    input  logic              close_v,
    input  ferr_t             close_err,
    output beat_t             beat
);
    logic              held_v;
    logic [BYTE_W-1:0] held_d;
    logic              held_sop;
    beat_t             beat_n;

    always_comb begin
        beat_n = '0;
        if (pay_v && held_v) begin
            beat_n.valid = 1'b1;
            beat_n.data  = held_d;
            beat_n.sop   = held_sop;
        end else if (close_v) begin
            beat_n.valid = 1'b1;
            beat_n.eop   = 1'b1;
            beat_n.err   = close_err;
            if (held_v) begin
                beat_n.data = held_d;
                beat_n.sop  = held_sop;
            end else begin
                beat_n.sop   = 1'b1;
                beat_n.empty = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat     <= '0;
            held_v   <= 1'b0;
            held_d   <= '0;
            held_sop <= 1'b0;
        end else begin
            beat <= beat_n;
            if (pay_v) begin
                held_v   <= 1'b1;
                held_d   <= pay_d;
                held_sop <= !held_v;
            end else if (close_v) begin
                held_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sir_deframer.sv
module sir_deframer
    import sir_deframer_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic [LEN_W-1:0] max_len,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_sop,
    output logic             out_eop,
    output logic             out_empty,
    output logic             out_err_noend,
    output logic             out_err_frame,
    output logic             out_err_len,
    output logic [LEN_W-1:0] byte_count,
    output logic [15:0]      flag_word
);
    sym_e        sym;
    logic        pay_v;
    logic [7:0]  pay_d;
    logic        close_v;
    ferr_t       close_err;
    beat_t       beat;

    sir_deframer_classify u_cls (
        .byte_in (in_byte),
        .sym     (sym)
    );

    sir_deframer_core #(.LEN_W(LEN_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .sym       (sym),
        .max_len   (max_len),
        .pay_v     (pay_v),
        .pay_d     (pay_d),
        .close_v   (close_v),
        .close_err (close_err),
        .count     (byte_count)
    );

    sir_deframer_outstage u_out (
        .clk       (clk),
        .rst       (rst),
        .pay_v     (pay_v),
        .pay_d     (pay_d),
        .close_v   (close_v),
        .close_err (close_err),
        .beat      (beat)
    );

    assign out_valid     = beat.valid;
    assign out_byte      = beat.data;
    assign out_sop       = beat.sop;
    assign out_eop       = beat.eop;
    assign out_empty     = beat.empty;
    assign out_err_noend = beat.err.noend;
    assign out_err_frame = beat.err.frame;
    assign out_err_len   = beat.err.len;
    assign flag_word     = FLAG_PAIR;
endmodule

// File: rtl/sir_deframer_checks.sv
module sir_deframer_checks #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [LEN_W-1:0] max_len,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic             out_empty,
    input logic             out_err_noend,
    input logic             out_err_frame,
    input logic             out_err_len,
    input logic [LEN_W-1:0] byte_count
);
    logic any_err;
    assign any_err = out_err_noend | out_err_frame | out_err_len;

    assert_marks_need_valid_R11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(out_sop | out_eop | out_empty | any_err));

    assert_err_on_end_R11: assert property (@(posedge clk) disable iff (rst)
        any_err |-> out_eop);

    assert_empty_marker_R6: assert property (@(posedge clk) disable iff (rst)
        out_empty |-> (out_sop && out_eop && out_valid));

    assert_beat_follows_input_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        (byte_count == '0) || (byte_count == $past(byte_count)) ||
        (byte_count == $past(byte_count) + LEN_W'(1)));

    assert_count_limit_R10: assert property (@(posedge clk) disable iff (rst)
        (byte_count != $past(byte_count) && byte_count != '0) |-> (byte_count <= max_len));
endmodule

bind sir_deframer sir_deframer_checks #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/sir_deframer_test.sv
module sir_deframer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [11:0] max_len = 12'd4095;
    logic        out_valid, out_sop, out_eop, out_empty;
    logic        out_err_noend, out_err_frame, out_err_len;
    logic [7:0]  out_byte;
    logic [11:0] byte_count;
    logic [15:0] flag_word;

    int checks = 0;
    int errors = 0;
    logic [13:0] got[$];
    logic [13:0] exp[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sir_deframer uut (.*);

    // beat code: {empty, noend, frame, len, sop, eop, data}
    always @(negedge clk)
        if (!rst && out_valid)
            got.push_back({out_empty, out_err_noend, out_err_frame, out_err_len,
                           out_sop, out_eop, out_byte});

    function automatic logic [13:0] mk(input logic [7:0] d, input logic s, input logic e,
                                       input logic [2:0] er, input logic em);
        return {em, er, s, e, d};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic compare(input string req);
        chk(got.size() == exp.size(), {req, " beat count"}, got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            chk(got[i] == exp[i], req, got[i], exp[i]);   // also covers R11 flag placement
        got.delete();
        exp.delete();
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R11 reset out_valid", out_valid, 0);
        chk(byte_count == 12'd0, "R9 reset count", byte_count, 0);
        chk(flag_word == 16'hC1C0, "R1 flag word", flag_word, 16'hC1C0);
    endtask

    task automatic t_timing();
        send(8'hC0); send(8'h11);
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R5 first byte held", out_valid, 0);
        send(8'h22);
        @(posedge clk); #1;
        chk(out_valid && out_byte == 8'h11 && out_sop && !out_eop, "R5 held byte out",
            {out_valid, out_sop, out_eop, out_byte}, {3'b110, 8'h11});
        send(8'hC1);
        @(posedge clk); #1;
        chk(out_valid && out_byte == 8'h22 && out_eop && !out_sop, "R6 eop with last byte",
            {out_valid, out_sop, out_eop, out_byte}, {3'b101, 8'h22});
        idle(2);
        got.delete();
    endtask

    task automatic t_basic();
        send(8'hFF); send(8'hFF); send(8'hC0); send(8'hC0);
        send(8'h11); send(8'h22); send(8'h33); send(8'hC1);
        idle(2);
        exp.push_back(mk(8'h11, 1, 0, 3'b000, 0));
        exp.push_back(mk(8'h22, 0, 0, 3'b000, 0));
        exp.push_back(mk(8'h33, 0, 1, 3'b000, 0));
        compare("R3 R5 basic frame with fill and repeated opening flags");
        chk(byte_count == 12'd3, "R9 count after frame", byte_count, 3);
    endtask

    task automatic t_outside();
        send(8'h55); send(8'hC1); send(8'hFF); send(8'h7D);
        idle(2);
        compare("R2 bytes outside frame");
        chk(byte_count == 12'd3, "R2 count untouched", byte_count, 3);
    endtask

    task automatic t_escape();
        send(8'hC0); send(8'h7D); send(8'h5E); send(8'h7D); send(8'h5D);
        send(8'h41); send(8'hC1);
        idle(2);
        exp.push_back(mk(8'h7E, 1, 0, 3'b000, 0));
        exp.push_back(mk(8'h7D, 0, 0, 3'b000, 0));
        exp.push_back(mk(8'h41, 0, 1, 3'b000, 0));
        compare("R4 escape removal");
        chk(byte_count == 12'd3, "R4 escapes not counted", byte_count, 3);
    endtask

    task automatic t_empty();
        send(8'hC0); send(8'hC1);
        idle(2);
        exp.push_back(mk(8'h00, 1, 1, 3'b000, 1));
        compare("R6 zero-length marker");
        chk(byte_count == 12'd0, "R9 count cleared on open", byte_count, 0);
    endtask

    task automatic t_noend();
        send(8'hC0); send(8'hA1); send(8'hA2); send(8'hC0); send(8'hB1); send(8'hC1);
        idle(2);
        exp.push_back(mk(8'hA1, 1, 0, 3'b000, 0));
        exp.push_back(mk(8'hA2, 0, 1, 3'b100, 0));
        exp.push_back(mk(8'hB1, 1, 1, 3'b000, 0));
        compare("R7 missing end flag");
        chk(byte_count == 12'd1, "R7 new frame count", byte_count, 1);
    endtask

    task automatic t_escend();
        send(8'hC0); send(8'h31); send(8'h7D); send(8'hC1);
        idle(2);
        exp.push_back(mk(8'h31, 1, 1, 3'b010, 0));
        compare("R8 escape before end flag");
    endtask

    task automatic t_length();
        max_len = 12'd3;
        send(8'hC0);
        for (int i = 1; i <= 5; i++) send(8'(i));
        send(8'hC1);
        idle(2);
        exp.push_back(mk(8'h01, 1, 0, 3'b000, 0));
        exp.push_back(mk(8'h02, 0, 0, 3'b000, 0));
        exp.push_back(mk(8'h03, 0, 1, 3'b001, 0));
        compare("R10 over-length frame");
        chk(byte_count == 12'd3, "R10 count stops at limit", byte_count, 3);
        send(8'hC0); send(8'h0A); send(8'h0B); send(8'h0C); send(8'hC1);
        idle(2);
        exp.push_back(mk(8'h0A, 1, 0, 3'b000, 0));
        exp.push_back(mk(8'h0B, 0, 0, 3'b000, 0));
        exp.push_back(mk(8'h0C, 0, 1, 3'b000, 0));
        compare("R10 exact-length frame");
        max_len = 12'd4095;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_timing();
        t_basic();
        t_outside();
        t_escape();
        t_empty();
        t_noend();
        t_escend();
        t_length();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule